// File: doc/BRIEF.md
# Two-Write Two-Read Replicated Memory

This block is a memory with two write ports and two read ports. All four ports can be used in the same clock cycle, with no stalls and no sharing of one RAM over time. It is built from four plain RAM copies, each with one write side and one read side and each holding the full depth. Each write port writes the same word into two copies, one for each read port. Copy (w,r) is written only by write port w and read only by read port r.

A one-bit owner table, held in ordinary registers, records which write port wrote each address last. A read port fetches the word from both of its copies and uses the owner bit to pick the current one. Reads are registered and take one cycle. A read of an address that is written in the same cycle returns the value from before the write. When both write ports hit one address in one cycle, write port 1 wins.

Top module: `twin_rw_mem`

## Requirements
- R1: Both write ports and both read ports can all be active in the same clock cycle without interfering. Two read ports given one address return identical data.
- R2: Read latency is one cycle. The word at the read address sampled on a rising edge appears on that port's read data after the edge.
- R3: A read of an address that is written at the same edge returns the value stored before that write. The new value is visible from the next read onwards.
- R4: When both write ports write one address at the same edge, the word from write port 1 is stored and later reads return it.
- R5: Every read returns the word from the most recent write to that address, whichever write port made it and whichever read port reads it.
- R6: While synchronous reset is high, both read data outputs are 0 after each rising edge.
- R7: A write port whose enable is low changes no stored word, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | AW | Write port 0 address |
| wr0_data | input | DW | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable; wins a same-address collision |
| wr1_addr | input | AW | Write port 1 address |
| wr1_data | input | DW | Write port 1 data |
| rd0_addr | input | AW | Read port 0 address |
| rd0_data | output | DW | Read port 0 data, one cycle after the address |
| rd1_addr | input | AW | Read port 1 address |
| rd1_data | output | DW | Read port 1 data, one cycle after the address |

## Verification
Two pairs of events can fall on the same edge: a write and a read of one address, and two writes to one address. The bench forces both cases on purpose. It reads an address on both read ports at the edge where it is being written, expects the old word, and expects the new word one cycle later. It also writes one address from both write ports at once and expects port 1's word. After that, long random traffic with a small address range makes both collisions happen often, and every read is checked against a model of a single array.

// File: rtl/twin_rw_pkg.sv
package twin_rw_pkg;
   localparam int NUM_WR = 2;
   localparam int NUM_RD = 2;

   // which write port owns the current copy of an address
   typedef enum logic {
      SRC_W0 = 1'b0,
      SRC_W1 = 1'b1
   } wr_src_e;
endpackage

// File: rtl/twin_rw_bank.sv
module twin_rw_bank #(
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rd
);
   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[wa] <= wd;
   end

   // registered read, returns the word from before a same-edge write
   always_ff @(posedge clk) begin
      if (rst) rd <= '0;
      else     rd <= store[ra];
   end
endmodule

// File: rtl/twin_rw_owner.sv
module twin_rw_owner
   import twin_rw_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we0,
   input  logic [AW-1:0] wa0,
   input  logic          we1,
   input  logic [AW-1:0] wa1,
   input  logic [AW-1:0] ra0,
   input  logic [AW-1:0] ra1,
   output wr_src_e       src0,
   output wr_src_e       src1
);
   logic [DEPTH-1:0] owner_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         owner_q <= '0;
         src0    <= SRC_W0;
         src1    <= SRC_W0;
      end else begin
         // port 1 is applied last so it wins a same-address collision
         if (we0) owner_q[wa0] <= SRC_W0;
         if (we1) owner_q[wa1] <= SRC_W1;
         src0 <= wr_src_e'(owner_q[ra0]);
         src1 <= wr_src_e'(owner_q[ra1]);
      end
   end
endmodule

// File: rtl/twin_rw_mem.sv
module twin_rw_mem
   import twin_rw_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr0_en,
   input  logic [AW-1:0] wr0_addr,
   input  logic [DW-1:0] wr0_data,
   input  logic          wr1_en,
   input  logic [AW-1:0] wr1_addr,
   input  logic [DW-1:0] wr1_data,
   input  logic [AW-1:0] rd0_addr,
   output logic [DW-1:0] rd0_data,
   input  logic [AW-1:0] rd1_addr,
   output logic [DW-1:0] rd1_data
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("twin_rw_mem: DW must be at least 1");
      end
      if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
         $error("twin_rw_mem: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic          we_v [NUM_WR];
   logic [AW-1:0] wa_v [NUM_WR];
   logic [DW-1:0] wd_v [NUM_WR];
   logic [AW-1:0] ra_v [NUM_RD];
   logic [DW-1:0] rd_v [NUM_RD];
   logic [DW-1:0] copy_q [NUM_WR][NUM_RD];
   wr_src_e       src_v [NUM_RD];

   assign we_v[0] = wr0_en;
   assign wa_v[0] = wr0_addr;
   assign wd_v[0] = wr0_data;
   assign we_v[1] = wr1_en;
   assign wa_v[1] = wr1_addr;
   assign wd_v[1] = wr1_data;
   assign ra_v[0] = rd0_addr;
   assign ra_v[1] = rd1_addr;

   // one copy per (write port, read port) pair
   for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
      for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
         twin_rw_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
            .clk (clk),
            .rst (rst),
            .we  (we_v[w]),
            .wa  (wa_v[w]),
            .wd  (wd_v[w]),
            .ra  (ra_v[r]),
            .rd  (copy_q[w][r])
         );
      end
   end

   twin_rw_owner #(.DEPTH(DEPTH)) u_owner (
      .clk  (clk),
      .rst  (rst),
      .we0  (wr0_en),
      .wa0  (wr0_addr),
      .we1  (wr1_en),
      .wa1  (wr1_addr),
      .ra0  (rd0_addr),
      .ra1  (rd1_addr),
      .src0 (src_v[0]),
      .src1 (src_v[1])
   );

   for (genvar r = 0; r < NUM_RD; r++) begin : g_pick
      assign rd_v[r] = (src_v[r] == SRC_W1) ? copy_q[1][r] : copy_q[0][r];
   end

   assign rd0_data = rd_v[0];
   assign rd1_data = rd_v[1];
endmodule

// File: rtl/twin_rw_mem_chk.sv
module twin_rw_mem_chk #(
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst,
   input logic          wr0_en,
   input logic [AW-1:0] wr0_addr,
   input logic [DW-1:0] wr0_data,
   input logic          wr1_en,
   input logic [AW-1:0] wr1_addr,
   input logic [DW-1:0] wr1_data,
   input logic [AW-1:0] rd0_addr,
   input logic [DW-1:0] rd0_data,
   input logic [AW-1:0] rd1_addr,
   input logic [DW-1:0] rd1_data
);
   AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (rd0_data == '0 && rd1_data == '0)); // R6

   AST_SAME_ADDR_AGREE: assert property (@(posedge clk) disable iff (rst)
      (rd0_addr == rd1_addr) |=> (rd0_data === rd1_data)); // R1

   AST_COLLIDE_W1: assert property (@(posedge clk) disable iff (rst)
      (wr0_en && wr1_en && wr0_addr == wr1_addr) ##1 (rd0_addr == $past(wr1_addr))
      |=> (rd0_data == $past(wr1_data, 2))); // R4

   AST_CROSS_PORT: assert property (@(posedge clk) disable iff (rst)
      (wr0_en && !(wr1_en && wr1_addr == wr0_addr)) ##1 (rd1_addr == $past(wr0_addr))
      |=> (rd1_data == $past(wr0_data, 2))); // R5

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
      ($past(!wr0_en && !wr1_en) && $stable(rd0_addr)) |=> $stable(rd0_data)); // R7
endmodule

bind twin_rw_mem twin_rw_mem_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr0_en   (wr0_en),
   .wr0_addr (wr0_addr),
   .wr0_data (wr0_data),
   .wr1_en   (wr1_en),
   .wr1_addr (wr1_addr),
   .wr1_data (wr1_data),
   .rd0_addr (rd0_addr),
   .rd0_data (rd0_data),
   .rd1_addr (rd1_addr),
   .rd1_data (rd1_data)
);

// File: tb/twin_rw_mem_bench.sv
`timescale 1ns/1ps
module twin_rw_mem_bench;
   localparam int DW    = 16;
   localparam int DEPTH = 16;
   localparam int AW    = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr0_en = 1'b0, wr1_en = 1'b0;
   logic [AW-1:0] wr0_addr = '0, wr1_addr = '0, rd0_addr = '0, rd1_addr = '0;
   logic [DW-1:0] wr0_data = '0, wr1_data = '0;
   logic [DW-1:0] rd0_data, rd1_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [DW-1:0] model [DEPTH];
   logic [DW-1:0] exp0_q [$];
   logic [DW-1:0] exp1_q [$];
   string         tag_q [$];

   always #10 clk = ~clk;   // 50 MHz

   twin_rw_mem #(.DW(DW), .DEPTH(DEPTH)) u_twin_rw_mem (
      .clk(clk), .rst(rst),
      .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
      .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
      .rd0_addr(rd0_addr), .rd0_data(rd0_data),
      .rd1_addr(rd1_addr), .rd1_data(rd1_data)
   );

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: one cycle of traffic, expected read data from the model
   task automatic cycle(bit e0, int a0, int d0, bit e1, int a1, int d1,
                        int r0, int r1, bit chk, string tag);
      @(negedge clk);
      wr0_en = e0; wr0_addr = AW'(a0); wr0_data = DW'(d0);
      wr1_en = e1; wr1_addr = AW'(a1); wr1_data = DW'(d1);
      rd0_addr = AW'(r0); rd1_addr = AW'(r1);
      if (chk) begin
         exp0_q.push_back(model[AW'(r0)]);
         exp1_q.push_back(model[AW'(r1)]);
         tag_q.push_back(tag);
      end
      if (e0) model[AW'(a0)] = DW'(d0);
      if (e1) model[AW'(a1)] = DW'(d1);   // port 1 wins
   endtask

   // monitor: compares one registered read per cycle, mid-high phase
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (tag_q.size() > 0) begin
            string t;
            logic [DW-1:0] e0, e1;
            t  = tag_q.pop_front();
            e0 = exp0_q.pop_front();
            e1 = exp1_q.pop_front();
            check({t, " rd0"}, rd0_data, e0);
            check({t, " rd1"}, rd1_data, e1);
         end
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #5;
      check("R6 reset rd0", rd0_data, '0);
      check("R6 reset rd1", rd1_data, '0);
      @(negedge clk);
      rst = 1'b0;

      // fill every address, both ports busy
      for (int a = 0; a < DEPTH; a += 2)
         cycle(1, a, 16'h1000 + a, 1, a + 1, 16'h2000 + a, 0, 0, 0, "");
      cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, "");

      // R2 R5: read back everything on both ports, reversed order on port 1
      for (int a = 0; a < DEPTH; a++)
         cycle(0, 0, 0, 0, 0, 0, a, DEPTH - 1 - a, 1, "R2");

      // R1: two writes and two reads on four distinct addresses
      cycle(1, 2, 16'hA1A1, 1, 9, 16'hB2B2, 4, 11, 1, "R1");
      cycle(0, 0, 0, 0, 0, 0, 2, 9, 1, "R1");
      cycle(0, 0, 0, 0, 0, 0, 9, 9, 1, "R1");

      // R3: write and read the same address at one edge
      cycle(1, 3, 16'h3333, 0, 0, 0, 3, 3, 1, "R3");
      cycle(0, 0, 0, 1, 6, 16'h6666, 3, 6, 1, "R3");
      cycle(0, 0, 0, 0, 0, 0, 6, 3, 1, "R3");

      // R4: both write ports on one address
      cycle(1, 5, 16'h0505, 1, 5, 16'h1515, 0, 0, 1, "R4");
      cycle(0, 0, 0, 0, 0, 0, 5, 5, 1, "R4");
      // R5: port 0 takes the address back
      cycle(1, 5, 16'h2525, 0, 0, 0, 5, 5, 1, "R5");
      cycle(0, 0, 0, 0, 0, 0, 5, 5, 1, "R5");

      // R7: disabled ports carry live-looking address and data
      cycle(0, 7, 16'hDEAD, 0, 7, 16'hBEEF, 7, 7, 1, "R7");
      cycle(0, 8, 16'hDEAD, 0, 8, 16'hBEEF, 7, 8, 1, "R7");
      cycle(0, 0, 0, 0, 0, 0, 8, 7, 1, "R7");

      // R5: random concurrent traffic in a narrow address range
      for (int i = 0; i < 400; i++)
         cycle(bit'($urandom_range(1)), $urandom_range(5), $urandom_range(16'hFFFF),
               bit'($urandom_range(1)), $urandom_range(5), $urandom_range(16'hFFFF),
               $urandom_range(5), $urandom_range(5), 1, "R5");

      cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
      repeat (2) @(posedge clk);
      #6;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule